// File: doc/BRIEF.md
# Cascaded Output Register Chain Controller

This block sits on the host side of a chain of cascaded serial-in, parallel-out output registers that switch loads such as LEDs, lamps or relays. It takes one status word of `CHAIN_BITS` bits per valid/ready handshake. It shifts the word out on a data line under a shift clock that the block generates. When the whole chain length has been shifted in, it issues one latch-clock pulse, so every load updates at the same moment. A 1 in the word switches its load on and a 0 switches it off. The chain applies this only while its active-low output enable is low.

The block drives the output-enable line with an 8-bit pulse-width modulator. The same line therefore dims every load in the chain together. After reset the block holds the chain's active-low clear line low for a short interval before it accepts any word. Cycle-count parameters set every timing interval, so the serial timing can be fitted to the system clock. With a 50 MHz clock and `HALF_CYC` = 3, each clock phase lasts 60 ns and the shift clock runs at 8.33 MHz. This meets the 15 ns setup and hold, the 40 ns minimum phase width and the 10 MHz cascade limit.

The controller states are:
- CLEAR, entered at reset, drives the clear line low and leaves for IDLE after `HALF_CYC` cycles.
- IDLE asserts ready and leaves for SHIFT on a handshake.
- SHIFT sends the bits, most significant first, and leaves for LATCH after the last bit.
- LATCH holds the latch clock low and then high, and returns to IDLE.

Top module: `chain_expander_ctrl`

## Requirements
- R1: During reset and for `HALF_CYC` cycles after reset release, `clear_n` is low while `word_ready`, `ser_clk` and `latch_clk` are low. After that, `clear_n` stays high.
- R2: `word_ready` is high only in IDLE. A word is taken at a rising clock edge where `word_valid` and `word_ready` are both high. `word_valid` and `word_data` have no effect while a word is in flight.
- R3: Each accepted word produces exactly `CHAIN_BITS` rising edges of `ser_clk`, with bit `CHAIN_BITS-1` sent first. A chain model that shifts `ser_data` into bit 0 on each rising edge then holds the word with word bit 0 in model bit 0, which is the first output of the stage nearest the host.
- R4: Within a word, every high phase and every low phase of `ser_clk` between rising edges lasts exactly `HALF_CYC` clock cycles.
- R5: `ser_data` changes only at the edge where `ser_clk` falls, or at the edge where a word is accepted. It is stable through every high phase of `ser_clk` and through the preceding low phase.
- R6: Each word produces exactly one `latch_clk` pulse, high for `HALF_CYC` cycles. It rises `HALF_CYC` cycles after the last falling edge of `ser_clk`, and only after all `CHAIN_BITS` rising edges. `ser_clk` is low whenever `latch_clk` is high.
- R7: `word_ready` returns high exactly 2·`HALF_CYC`·(`CHAIN_BITS`+1) cycles after the accepting edge.
- R8: In every 256-cycle modulator period, `out_en_n` is low for exactly `pwm_duty` cycles (0 to 255). A duty of 0 keeps it high. A new duty takes effect at the next period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_data | input | CHAIN_BITS | Status word, 1 = load on |
| word_valid | input | 1 | Word offered |
| word_ready | output | 1 | Controller idle, can take a word |
| pwm_duty | input | 8 | Enable-low cycles per 256-cycle period |
| ser_data | output | 1 | Serial data to the first stage |
| ser_clk | output | 1 | Shift clock to all stages |
| latch_clk | output | 1 | Storage (latch) clock to all stages |
| out_en_n | output | 1 | Active-low output enable, PWM dimmed |
| clear_n | output | 1 | Active-low chain clear |

## Verification
All outputs are decoded from registered state without further delay. A change in state caused by an edge can therefore be seen at the following falling clock edge, and the bench samples only there.

From the accepting edge, the bench expects 2·`HALF_CYC`·(`CHAIN_BITS`+1) busy cycles before ready returns. It expects phase runs of exactly `HALF_CYC` samples and a latch rise exactly `HALF_CYC` samples after the last shift-clock fall. It measures the clear interval from the release sample itself.

For the modulator, the bench holds each duty for two full periods before it counts low samples over a 256-cycle window. This keeps the count clear of the period-boundary update.

// File: rtl/exp_pkg.sv
package exp_pkg;
    typedef enum logic [1:0] {
        S_CLEAR = 2'd0,
        S_IDLE  = 2'd1,
        S_SHIFT = 2'd2,
        S_LATCH = 2'd3
    } exp_state_t;

    typedef enum logic {
        PH_LO = 1'b0,
        PH_HI = 1'b1
    } exp_phase_t;
endpackage

// File: rtl/exp_phase_timer.sv
module exp_phase_timer #(
    parameter int HALF_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int CW = (HALF_CYC < 2) ? 1 : $clog2(HALF_CYC);

    logic [CW-1:0] cnt;

    assign last = run && (cnt == CW'(HALF_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || last)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/exp_pwm.sv
module exp_pwm #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] duty,
    output logic          en_n
);
    logic [PW-1:0] cnt;
    logic [PW-1:0] duty_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            duty_q <= '0;
        end else begin
            cnt <= cnt + 1'b1;
            if (cnt == {PW{1'b1}})
                duty_q <= duty;
        end
    end

    assign en_n = !(cnt < duty_q);
endmodule

// File: rtl/chain_expander_ctrl.sv
module chain_expander_ctrl
    import exp_pkg::*;
#(
    parameter int CHAIN_BITS = 16,
    parameter int HALF_CYC   = 3,
    parameter int PWM_BITS   = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CHAIN_BITS-1:0] word_data,
    input  logic                  word_valid,
    output logic                  word_ready,
    input  logic [PWM_BITS-1:0]   pwm_duty,
    output logic                  ser_data,
    output logic                  ser_clk,
    output logic                  latch_clk,
    output logic                  out_en_n,
    output logic                  clear_n
);
    localparam int BW = (CHAIN_BITS < 2) ? 1 : $clog2(CHAIN_BITS);
    localparam logic [BW-1:0] LAST_BIT = BW'(CHAIN_BITS - 1);

    exp_state_t            state, state_d;
    exp_phase_t            phase;
    logic [CHAIN_BITS-1:0] shreg;
    logic [BW-1:0]         bit_cnt;
    logic                  ph_last;

    exp_phase_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state != S_IDLE),
        .last (ph_last)
    );

    exp_pwm #(.PW(PWM_BITS)) u_pwm (
        .clk  (clk),
        .rst_n(rst_n),
        .duty (pwm_duty),
        .en_n (out_en_n)
    );

    // next-state decode
    always_comb begin
        state_d = state;
        unique case (state)
            S_CLEAR: if (ph_last) state_d = S_IDLE;
            S_IDLE:  if (word_valid) state_d = S_SHIFT;
            S_SHIFT: if (ph_last && phase == PH_HI && bit_cnt == LAST_BIT)
                         state_d = S_LATCH;
            S_LATCH: if (ph_last && phase == PH_HI) state_d = S_IDLE;
            default: state_d = S_CLEAR;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_CLEAR;
            phase   <= PH_LO;
            shreg   <= '0;
            bit_cnt <= '0;
        end else begin
            state <= state_d;
            unique case (state)
                S_IDLE: begin
                    if (word_valid) begin
                        shreg   <= word_data;
                        bit_cnt <= '0;
                        phase   <= PH_LO;
                    end
                end
                S_SHIFT: begin
                    if (ph_last) begin
                        if (phase == PH_HI) begin
                            phase   <= PH_LO;
                            shreg   <= {shreg[CHAIN_BITS-2:0], 1'b0};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else begin
                            phase <= PH_HI;
                        end
                    end
                end
                S_LATCH: begin
                    if (ph_last)
                        phase <= (phase == PH_HI) ? PH_LO : PH_HI;
                end
                default: phase <= PH_LO;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        word_ready = (state == S_IDLE);
        clear_n    = (state != S_CLEAR);
        ser_clk    = (state == S_SHIFT) && (phase == PH_HI);
        ser_data   = (state == S_SHIFT) ? shreg[CHAIN_BITS-1] : 1'b0;
        latch_clk  = (state == S_LATCH) && (phase == PH_HI);
    end
endmodule

// File: rtl/exp_ctrl_checker.sv
module exp_ctrl_checker (
    input logic clk,
    input logic rst_n,
    input logic word_ready,
    input logic ser_data,
    input logic ser_clk,
    input logic latch_clk,
    input logic clear_n
);
    AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_n |-> (!word_ready && !ser_clk && !latch_clk)); // R1

    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        word_ready |-> (!ser_clk && !latch_clk && clear_n)); // R2

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data)); // R5

    AST_DATA_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ser_data) |-> ($fell(ser_clk) || $past(word_ready))); // R5

    AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        latch_clk |-> !ser_clk); // R6

    AST_LATCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latch_clk) |-> !word_ready); // R6
endmodule

bind chain_expander_ctrl exp_ctrl_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_ready(word_ready),
    .ser_data  (ser_data),
    .ser_clk   (ser_clk),
    .latch_clk (latch_clk),
    .clear_n   (clear_n)
);

// File: tb/chain_expander_ctrl_tb.sv
`timescale 1ns/1ps
module chain_expander_ctrl_tb;
    localparam int N = 16;
    localparam int H = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] word_data = '0;
    logic         word_valid = 1'b0;
    logic [7:0]   pwm_duty = 8'd0;
    logic         word_ready, ser_data, ser_clk, latch_clk, out_en_n, clear_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    chain_expander_ctrl #(.CHAIN_BITS(N), .HALF_CYC(H)) u_dut (
        .clk(clk), .rst_n(rst_n), .word_data(word_data), .word_valid(word_valid),
        .word_ready(word_ready), .pwm_duty(pwm_duty), .ser_data(ser_data),
        .ser_clk(ser_clk), .latch_clk(latch_clk), .out_en_n(out_en_n), .clear_n(clear_n)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // chain model and serial timing monitor
    logic [N-1:0] model_sr = '0;
    logic [N-1:0] storage = '0;
    int sclk_rises = 0, latch_rises = 0;
    int run_len = 0, since_fall = 0, latch_len = 0;
    logic prev_sclk = 0, prev_latch = 0, prev_sdo = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_sclk = 0; prev_latch = 0; prev_sdo = 0;
            run_len = 0; since_fall = 0; latch_len = 0;
        end else begin
            if (ser_clk && !prev_sclk) begin
                if (sclk_rises > 0) chk(run_len == H, "R4 low phase", run_len, H);
                chk(ser_data == prev_sdo, "R5 setup", ser_data, prev_sdo);
                model_sr = {model_sr[N-2:0], ser_data};
                sclk_rises++;
                run_len = 1;
            end else if (!ser_clk && prev_sclk) begin
                chk(run_len == H, "R4 high phase", run_len, H);
                run_len = 1;
                since_fall = 1;
            end else begin
                if (ser_clk) chk(ser_data == prev_sdo, "R5 hold", ser_data, prev_sdo);
                run_len++;
                if (!latch_clk && !prev_latch) since_fall++;
            end
            if (latch_clk && !prev_latch) begin
                chk(since_fall == H, "R6 gap after last fall", since_fall, H);
                chk(sclk_rises == N, "R6 latch after all bits", sclk_rises, N);
                storage = model_sr;
                latch_rises++;
                latch_len = 1;
            end else if (!latch_clk && prev_latch) begin
                chk(latch_len == H, "R6 latch width", latch_len, H);
            end else if (latch_clk) begin
                latch_len++;
            end
            prev_sclk = ser_clk; prev_latch = latch_clk; prev_sdo = ser_data;
        end
    end

    task automatic send(input logic [N-1:0] w, input bit poke_busy, input logic [N-1:0] w2);
        int busy;
        sclk_rises = 0;
        latch_rises = 0;
        @(negedge clk);
        chk(word_ready == 1'b1, "R2 ready in idle", word_ready, 1);
        word_data = w;
        word_valid = 1'b1;
        @(negedge clk);
        if (poke_busy) begin
            word_data = w2;
            busy = 0;
            repeat (10) begin
                if (word_ready == 1'b0) busy++;
                @(negedge clk);
            end
            word_valid = 1'b0;
            word_data = ~w2;
        end else begin
            word_valid = 1'b0;
            word_data = ~w;
            busy = 0;
        end
        while (word_ready == 1'b0 && busy < 1000) begin
            busy++;
            @(negedge clk);
        end
        chk(busy == 2*H*(N+1), "R7 busy length", busy, 2*H*(N+1));
        chk(sclk_rises == N, "R3 shift clock count", sclk_rises, N);
        chk(latch_rises == 1, "R6 single latch", latch_rises, 1);
        chk(storage == w, poke_busy ? "R2 busy offer ignored" : "R3 word in chain", storage, w);
    endtask

    initial begin
        int lowc;
        repeat (4) @(negedge clk);
        chk(clear_n == 1'b0, "R1 clear in reset", clear_n, 0);
        chk(word_ready == 1'b0, "R1 not ready in reset", word_ready, 0);
        chk(ser_clk == 1'b0 && latch_clk == 1'b0, "R1 clocks quiet", {ser_clk, latch_clk}, 0);
        chk(out_en_n == 1'b1, "R8 enable off at reset", out_en_n, 1);
        rst_n = 1'b1;
        #1;
        lowc = 1;
        chk(clear_n == 1'b0, "R1 clear after release", clear_n, 0);
        @(negedge clk);
        while (clear_n == 1'b0 && lowc < 100) begin
            chk(word_ready == 1'b0, "R1 not ready while clearing", word_ready, 0);
            lowc++;
            @(negedge clk);
        end
        chk(lowc == H, "R1 clear length", lowc, H);

        send(16'h0000, 0, '0);
        send(16'hFFFF, 0, '0);
        send(16'hA5C3, 0, '0);
        send(16'h5A3C, 0, '0);
        send(16'h0001, 0, '0);
        chk(storage[0] == 1'b1 && storage[N-1:1] == '0, "R3 bit0 nearest stage", storage, 1);
        for (int i = 0; i < N; i++) send(N'(1) << i, 0, '0);
        for (int i = 0; i < N; i++) send(~(N'(1) << i), 0, '0);
        send(16'h1234, 1, 16'hFEDC);

        for (int k = 0; k < 10; k++) begin
            int d;
            int lows;
            case (k)
                0: d = 0;   1: d = 1;   2: d = 2;   3: d = 3;   4: d = 64;
                5: d = 127; 6: d = 128; 7: d = 200; 8: d = 254; default: d = 255;
            endcase
            @(negedge clk);
            pwm_duty = 8'(d);
            repeat (512) @(negedge clk);
            lows = 0;
            repeat (256) begin
                @(negedge clk);
                if (out_en_n == 1'b0) lows++;
            end
            chk(lows == d, "R8 duty low count", lows, d);
        end
        chk(clear_n == 1'b1, "R1 clear stays high", clear_n, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule